// File: doc/BRIEF.md
# SPI Pad Router

This block stands between the core of a serial peripheral interface controller and its I/O pads. The core hands it one serial output bit, a transmit-enable, and a request for each chip-select line. The router turns these into the value and output-enable of two bidirectional data pads and four chip-select pads. It also hands the core the receive bit, captured from whichever pad currently carries input.

A static configuration picks the routing. A 2-bit pin mode assigns the data pads: one pad for input and the other for output in either orientation, or a single shared pad that carries both directions. A 4-bit polarity field sets each chip-select line to active high or active low. A disable bit retires the upper chip-select lines. An idle bit controls the output pad while no chip select is asserted: it either keeps driving the last bit or releases the pad.

The shift engine, clock generation, FIFOs and register access are outside this block. All configuration inputs are 0 after reset.

Top module: `spi_pad_router`

## Requirements
- R1: With `cfg_pin_mode` = 0 (split), `dio1` drives `core_sdo`, `dio0` is never driven, and `core_sdi` returns the `dio0_in` value sampled at the previous clock edge.
- R2: With `cfg_pin_mode` = 3 (swapped split), `dio0` drives `core_sdo`, `dio1` is never driven, and `core_sdi` returns the `dio1_in` value sampled at the previous clock edge.
- R3: With `cfg_pin_mode` = 1 (shared `dio0`) or 2 (shared `dio1`), the shared pad's output enable equals `core_tx_en` while a frame is active. `core_sdi` takes that pad's input at an edge where its enable is low, and otherwise keeps its previous value.
- R4: In mode 1 `dio1_oe` is always 0, and in mode 2 `dio0_oe` is always 0.
- R5: With `cfg_idle_tri` = 0 and no enabled chip-select request, the output pad stays enabled. It carries the last bit that was driven during a frame, or 0 if no bit has been driven since reset. In shared modes it is also gated by `core_tx_en`.
- R6: With `cfg_idle_tri` = 1 and no enabled chip-select request, both data pads have their output enable at 0.
- R7: Chip-select line i is active high when `cfg_cs_pol[i]` = 1 and active low when it is 0. `cs_pin` is registered, so a change of request or polarity appears only after the next rising clock edge.
- R8: When `cfg_upper_off` = 1, lines 2 and 3 sit at their inactive level and their requests are ignored. This includes not counting as an active frame.
- R9: While `rst_n` is low, `cs_oe`, `dio0_oe` and `dio1_oe` are all 0, `cs_pin` is all ones and `core_sdi` is 0.
- R10: From the second rising edge after `rst_n` rises, `cs_oe` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pin_mode | input | 2 | Data pad assignment: 0 split, 1 shared dio0, 2 shared dio1, 3 swapped split |
| cfg_idle_tri | input | 1 | 1 releases the output pad between frames |
| cfg_cs_pol | input | 4 | Per-line chip-select polarity, 1 = active high |
| cfg_upper_off | input | 1 | 1 disables chip-select lines 2 and 3 |
| core_sdo | input | 1 | Serial output bit from the core |
| core_tx_en | input | 1 | Core transmit enable (shared modes) |
| core_cs_req | input | 4 | Chip-select requests, 1 = select |
| core_sdi | output | 1 | Registered receive bit to the core |
| dio0_in | input | 1 | Pad 0 input |
| dio0_out | output | 1 | Pad 0 output value |
| dio0_oe | output | 1 | Pad 0 output enable |
| dio1_in | input | 1 | Pad 1 input |
| dio1_out | output | 1 | Pad 1 output value |
| dio1_oe | output | 1 | Pad 1 output enable |
| cs_pin | output | 4 | Chip-select pad levels |
| cs_oe | output | 4 | Chip-select pad output enables |

## Verification
Most of the router's state shows up at the pads within one cycle. A corrupted chip-select flop gives a wrong `cs_pin` level right after the following edge. A wrong mode decode appears at once as a pad driven in the wrong direction. Two states are slower to reveal themselves. The idle hold register is only visible once the frame ends, as a wrong idle level. The receive register is only visible through `core_sdi` one edge after the pad input changes, and in shared modes only while the pad is released. The scoreboard therefore drives frames that end in idle, and toggles the transmit-enable in the shared modes.

// File: rtl/spi_rt_pkg.sv
package spi_rt_pkg;
   typedef enum logic [1:0] {
      PM_SPLIT   = 2'd0,
      PM_SHARE_A = 2'd1,
      PM_SHARE_B = 2'd2,
      PM_SWAP    = 2'd3
   } pin_mode_e;

   typedef struct packed {
      logic val;
      logic oe;
   } pad_drv_t;
endpackage

// File: rtl/sr_cs_line.sv
module sr_cs_line (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic pol,
   input  logic off,
   output logic eff,
   output logic pin
);
   assign eff = req & ~off;

   // registered pad level: the polarity and request settle at the edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b1;
      else        pin <= pol ? eff : ~eff;
   end
endmodule

// File: rtl/sr_tx_steer.sv
module sr_tx_steer
   import spi_rt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      live,
   input  logic      active,
   input  logic      idle_tri,
   input  logic      tx_en,
   input  logic      sdo,
   output pad_drv_t  drv_a,
   output pad_drv_t  drv_b
);
   logic hold_q;
   logic shared;
   logic drv_val;
   logic dual_oe;
   logic one_oe;

   assign shared  = (mode == PM_SHARE_A) || (mode == PM_SHARE_B);
   assign drv_val = active ? sdo : hold_q;
   assign dual_oe = live & (active | ~idle_tri);
   assign one_oe  = dual_oe & tx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= 1'b0;
      else if (active && (!shared || tx_en))
         hold_q <= sdo;
   end

   always_comb begin
      drv_a = '0;
      drv_b = '0;
      unique case (mode)
         PM_SPLIT:   drv_b = '{val: drv_val, oe: dual_oe};
         PM_SWAP:    drv_a = '{val: drv_val, oe: dual_oe};
         PM_SHARE_A: drv_a = '{val: drv_val, oe: one_oe};
         PM_SHARE_B: drv_b = '{val: drv_val, oe: one_oe};
         default:    ;
      endcase
   end
endmodule

// File: rtl/sr_rx_pick.sv
module sr_rx_pick
   import spi_rt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_e mode,
   input  logic      a_in,
   input  logic      a_oe,
   input  logic      b_in,
   input  logic      b_oe,
   output logic      sdi
);
   logic src_in;
   logic src_oe;

   always_comb begin
      if (mode == PM_SPLIT || mode == PM_SHARE_A) begin
         src_in = a_in;
         src_oe = a_oe;
      end else begin
         src_in = b_in;
         src_oe = b_oe;
      end
   end

   // capture only while the source pad is released
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sdi <= 1'b0;
      else if (!src_oe) sdi <= src_in;
   end
endmodule

// File: rtl/spi_pad_router.sv
module spi_pad_router
   import spi_rt_pkg::*;
#(
   parameter int NUM_CS      = 4,
   parameter int UPPER_FIRST = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_pin_mode,
   input  logic              cfg_idle_tri,
   input  logic [NUM_CS-1:0] cfg_cs_pol,
   input  logic              cfg_upper_off,
   input  logic              core_sdo,
   input  logic              core_tx_en,
   input  logic [NUM_CS-1:0] core_cs_req,
   output logic              core_sdi,
   input  logic              dio0_in,
   output logic              dio0_out,
   output logic              dio0_oe,
   input  logic              dio1_in,
   output logic              dio1_out,
   output logic              dio1_oe,
   output logic [NUM_CS-1:0] cs_pin,
   output logic [NUM_CS-1:0] cs_oe
);
   localparam int NUM_UPPER = NUM_CS - UPPER_FIRST;

   generate
      if (NUM_CS < 2 || UPPER_FIRST < 1 || NUM_UPPER < 1) begin : g_bad_cfg
         $error("spi_pad_router: UPPER_FIRST must lie inside 1..NUM_CS-1");
      end
   endgenerate

   pin_mode_e         mode;
   logic              live_q;
   logic [NUM_CS-1:0] eff;
   logic [NUM_CS-1:0] line_off;
   logic              frame_act;
   pad_drv_t          drv_a;
   pad_drv_t          drv_b;

   assign mode = pin_mode_e'(cfg_pin_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_line
         if (i >= UPPER_FIRST) begin : g_upper
            assign line_off[i] = cfg_upper_off;
         end else begin : g_lower
            assign line_off[i] = 1'b0;
         end
         sr_cs_line u_line (
            .clk (clk),
            .rst_n (rst_n),
            .req (core_cs_req[i]),
            .pol (cfg_cs_pol[i]),
            .off (line_off[i]),
            .eff (eff[i]),
            .pin (cs_pin[i])
         );
      end
   endgenerate

   assign frame_act = |eff;
   assign cs_oe     = {NUM_CS{live_q}};

   sr_tx_steer u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .live     (live_q),
      .active   (frame_act),
      .idle_tri (cfg_idle_tri),
      .tx_en    (core_tx_en),
      .sdo      (core_sdo),
      .drv_a    (drv_a),
      .drv_b    (drv_b)
   );

   assign dio0_out = drv_a.val;
   assign dio0_oe  = drv_a.oe;
   assign dio1_out = drv_b.val;
   assign dio1_oe  = drv_b.oe;

   sr_rx_pick u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .a_in  (dio0_in),
      .a_oe  (dio0_oe),
      .b_in  (dio1_in),
      .b_oe  (dio1_oe),
      .sdi   (core_sdi)
   );
endmodule

// File: rtl/spi_pad_router_chk.sv
module spi_pad_router_chk #(
   parameter int NUM_CS      = 4,
   parameter int UPPER_FIRST = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cfg_pin_mode,
   input logic              cfg_idle_tri,
   input logic [NUM_CS-1:0] cfg_cs_pol,
   input logic              cfg_upper_off,
   input logic              core_sdo,
   input logic              core_tx_en,
   input logic [NUM_CS-1:0] core_cs_req,
   input logic              dio0_out,
   input logic              dio0_oe,
   input logic              dio1_out,
   input logic              dio1_oe,
   input logic [NUM_CS-1:0] cs_pin,
   input logic [NUM_CS-1:0] cs_oe
);
   logic [NUM_CS-1:0] keep_mask;
   logic              act_c;

   always_comb begin
      for (int i = 0; i < NUM_CS; i++)
         keep_mask[i] = !(cfg_upper_off && (i >= UPPER_FIRST));
   end
   assign act_c = |(core_cs_req & keep_mask);

   // R1
   r1_split_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && cfg_pin_mode == 2'd0 && act_c) |->
      (dio1_oe && dio1_out == core_sdo && !dio0_oe));

   // R2
   r2_swap_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && cfg_pin_mode == 2'd3 && act_c) |->
      (dio0_oe && dio0_out == core_sdo && !dio1_oe));

   // R3
   r3_shared_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && act_c && (cfg_pin_mode == 2'd1 || cfg_pin_mode == 2'd2)) |->
      ((cfg_pin_mode == 2'd1 ? dio0_oe : dio1_oe) == core_tx_en));

   // R4
   r4_unused_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pin_mode == 2'd1 || cfg_pin_mode == 2'd2) |->
      (cfg_pin_mode == 2'd1 ? !dio1_oe : !dio0_oe));

   // R5
   r5_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && cfg_pin_mode == 2'd0 && $past(cfg_pin_mode) == 2'd0 &&
       !cfg_idle_tri && !act_c && !$past(act_c)) |-> $stable(dio1_out));

   // R6
   r6_idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_idle_tri && !act_c) |-> (!dio0_oe && !dio1_oe));

   // R7
   r7_cs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && $stable(core_cs_req) && $stable(cfg_cs_pol) && $stable(cfg_upper_off))
      |=> $stable(cs_pin));

   // R8
   r8_upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_oe[0] && $past(cfg_upper_off)) |->
      (cs_pin[NUM_CS-1] == !$past(cfg_cs_pol[NUM_CS-1]) &&
       cs_pin[UPPER_FIRST] == !$past(cfg_cs_pol[UPPER_FIRST])));

   // R10
   r10_cs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (&cs_oe));
endmodule

bind spi_pad_router spi_pad_router_chk #(
   .NUM_CS      (NUM_CS),
   .UPPER_FIRST (UPPER_FIRST)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_pin_mode  (cfg_pin_mode),
   .cfg_idle_tri  (cfg_idle_tri),
   .cfg_cs_pol    (cfg_cs_pol),
   .cfg_upper_off (cfg_upper_off),
   .core_sdo      (core_sdo),
   .core_tx_en    (core_tx_en),
   .core_cs_req   (core_cs_req),
   .dio0_out      (dio0_out),
   .dio0_oe       (dio0_oe),
   .dio1_out      (dio1_out),
   .dio1_oe       (dio1_oe),
   .cs_pin        (cs_pin),
   .cs_oe         (cs_oe)
);

// File: tb/sim_spi_pad_router.sv
`timescale 1ns/1ps
module sim_spi_pad_router;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] cfg_pin_mode = 2'd0;
   logic       cfg_idle_tri = 1'b0;
   logic [3:0] cfg_cs_pol = 4'h0;
   logic       cfg_upper_off = 1'b0;
   logic       core_sdo = 1'b0;
   logic       core_tx_en = 1'b0;
   logic [3:0] core_cs_req = 4'h0;
   logic       core_sdi;
   logic       dio0_in = 1'b0;
   logic       dio0_out, dio0_oe;
   logic       dio1_in = 1'b0;
   logic       dio1_out, dio1_oe;
   logic [3:0] cs_pin, cs_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [3:0] cs;
      logic       d0oe, d0v, d1oe, d1v, sdi;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   logic m_hold = 1'b0;
   logic m_sdi  = 1'b0;
   logic [3:0] m_cs = 4'hF;

   always #2.5 clk = ~clk;

   spi_pad_router u0 (
      .clk (clk), .rst_n (rst_n),
      .cfg_pin_mode (cfg_pin_mode), .cfg_idle_tri (cfg_idle_tri),
      .cfg_cs_pol (cfg_cs_pol), .cfg_upper_off (cfg_upper_off),
      .core_sdo (core_sdo), .core_tx_en (core_tx_en), .core_cs_req (core_cs_req),
      .core_sdi (core_sdi),
      .dio0_in (dio0_in), .dio0_out (dio0_out), .dio0_oe (dio0_oe),
      .dio1_in (dio1_in), .dio1_out (dio1_out), .dio1_oe (dio1_oe),
      .cs_pin (cs_pin), .cs_oe (cs_oe)
   );

   task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // driver: apply one setting at a falling edge, push what the requirements predict
   task automatic step(input logic [1:0] m, input logic it, input logic [3:0] pol,
                       input logic uo, input logic sdo, input logic txen,
                       input logic [3:0] req, input logic in0, input logic in1,
                       input bit pre_chk, input string tag);
      exp_t e;
      logic [3:0] eff;
      logic act, dval, dual, one, src_in, src_oe;
      @(negedge clk);
      cfg_pin_mode = m; cfg_idle_tri = it; cfg_cs_pol = pol; cfg_upper_off = uo;
      core_sdo = sdo; core_tx_en = txen; core_cs_req = req;
      dio0_in = in0; dio1_in = in1;
      if (pre_chk) begin
         #1;
         // R7: registered, so nothing moves before the edge
         check_bit("R7", "cs_pin[0] before edge", cs_pin[0], m_cs[0]);
         check_bit("R7", "cs_pin[1] before edge", cs_pin[1], m_cs[1]);
      end
      for (int i = 0; i < 4; i++) begin
         eff[i] = req[i] & !(uo && i >= 2);
         e.cs[i] = pol[i] ? eff[i] : !eff[i];
      end
      act  = |eff;
      dval = act ? sdo : m_hold;
      dual = act | !it;
      one  = dual & txen;
      e.d0oe = 1'b0; e.d0v = 1'b0; e.d1oe = 1'b0; e.d1v = 1'b0;
      case (m)
         2'd0: begin e.d1oe = dual; e.d1v = dval; end
         2'd3: begin e.d0oe = dual; e.d0v = dval; end
         2'd1: begin e.d0oe = one;  e.d0v = dval; end
         default: begin e.d1oe = one; e.d1v = dval; end
      endcase
      src_in = (m == 2'd0 || m == 2'd1) ? in0 : in1;
      src_oe = (m == 2'd0 || m == 2'd1) ? e.d0oe : e.d1oe;
      if (!src_oe) m_sdi = src_in;
      if (act && (m == 2'd0 || m == 2'd3 || txen)) m_hold = sdo;
      e.sdi = m_sdi;
      e.tag = tag;
      m_cs  = e.cs;
      sb_q.push_back(e);
   endtask

   // monitor: compare one predicted item per cycle, just after the rising edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_tests++;
            if (cs_pin !== e.cs) begin
               n_fail++;
               $display("FAIL %s cs_pin: actual %b expected %b", e.tag, cs_pin, e.cs);
            end
            check_bit(e.tag, "cs_oe (R10)", &cs_oe, 1'b1);
            check_bit(e.tag, "dio0_oe", dio0_oe, e.d0oe);
            check_bit(e.tag, "dio1_oe", dio1_oe, e.d1oe);
            if (e.d0oe) check_bit(e.tag, "dio0_out", dio0_out, e.d0v);
            if (e.d1oe) check_bit(e.tag, "dio1_out", dio1_out, e.d1v);
            check_bit(e.tag, "core_sdi", core_sdi, e.sdi);
         end
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check_bit("R9", "cs_oe", |cs_oe, 1'b0);
      check_bit("R9", "dio0_oe", dio0_oe, 1'b0);
      check_bit("R9", "dio1_oe", dio1_oe, 1'b0);
      check_bit("R9", "cs_pin", &cs_pin, 1'b1);
      check_bit("R9", "core_sdi", core_sdi, 1'b0);
      rst_n = 1'b1;

      // R1 split routing
      step(2'd0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b1, 1'b0, "R1 split a");
      step(2'd0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, "R1 split b");
      // R2 swapped routing
      step(2'd3, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'b0010, 1'b1, 1'b0, 1'b0, "R2 swap a");
      step(2'd3, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'b0100, 1'b0, 1'b1, 1'b0, "R2 swap b");
      // R5 idle hold after frames ending in 0 and in 1
      step(2'd0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, "R5 hold 0");
      step(2'd0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 4'b1000, 1'b0, 1'b0, 1'b0, "R5 frame 1");
      step(2'd0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, "R5 hold 1");
      // R6 idle release
      step(2'd0, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0, "R6 idle tri");
      step(2'd3, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b0, 1'b1, 1'b0, "R6 idle tri swap");
      // R3 / R4 shared dio0
      step(2'd1, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0001, 1'b0, 1'b1, 1'b0, "R3 R4 share0 tx");
      step(2'd1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 1'b1, 1'b0, 1'b0, "R3 R4 share0 rx");
      step(2'd1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 4'b0001, 1'b0, 1'b0, 1'b0, "R3 share0 hold rx");
      // R3 / R4 shared dio1
      step(2'd2, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0, "R3 R4 share1 rx");
      step(2'd2, 1'b0, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0010, 1'b1, 1'b1, 1'b0, "R3 R4 share1 tx");
      step(2'd2, 1'b1, 4'h0, 1'b0, 1'b1, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, "R3 R6 share1 idle");
      // R7 polarity per line, registered
      step(2'd0, 1'b0, 4'b1010, 1'b0, 1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 1'b1, "R7 pol mix");
      step(2'd0, 1'b0, 4'b0101, 1'b0, 1'b0, 1'b0, 4'b0011, 1'b0, 1'b0, 1'b1, "R7 pol swap");
      // R8 upper lines disabled
      step(2'd0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 4'b1100, 1'b0, 1'b0, 1'b0, "R8 upper off low");
      step(2'd0, 1'b1, 4'b1111, 1'b1, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, 1'b0, "R8 upper off high");
      step(2'd0, 1'b1, 4'b1111, 1'b0, 1'b1, 1'b0, 4'b1100, 1'b0, 1'b0, 1'b0, "R8 upper back on");

      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule